// File: doc/BRIEF.md
# Digital Audio Receiver Error Hold and Flag Logic

This block sits between a two-channel digital audio interface decoder and the serial output port. It takes one decoded subframe at a time: a 24-bit audio word, a tag saying whether the word belongs to the first (A) or second (B) channel, and the parity, biphase and validity flags found with it, plus the lock indication of the clock recovery loop. Channel A words feed the left output slot and channel B words feed the right output slot. A frame ends when a B subframe is accepted, and at that point one stereo pair is presented.

Any subframe that carries an error, or that arrives while the loop is unlocked, does not reach the output. The last good word of the same channel is repeated in its place for as long as the fault lasts. If software enables it, a run of held frames longer than a programmable limit turns into silence, and the first clean frame brings the audio back. A single error pin reports a per-frame latched OR of the enabled error flags, and a loss of lock drives it high at once. A status register gives the unmasked flags of the last completed frame. Output words are cut to 16 or 20 MSBs when the serial format needs it.

Top module: `spdif_err_hold`

## Requirements
- R1: During and right after reset, `left_out`, `right_out`, `status` and `out_valid` are zero and `err_pin` is low while `locked` is high.
- R2: `out_valid` is high for exactly the one cycle after a B subframe is accepted (`sub_valid` and `sub_chan_b` high), and only then. `left_out` and `right_out` are updated in that same cycle, with left taken from channel A and right taken from channel B.
- R3: A subframe accepted with no parity error, no biphase error, validity bit clear and `locked` high reaches its output slot unchanged when `fmt_sel` is 0.
- R4: A subframe with a parity error, a biphase error or a set validity bit, or one received while `locked` is low, is replaced by the last good word of its own channel. The other channel is not affected.
- R5: With `mute_en` high, once a frame is the `hold_limit`-th consecutive frame with at least one replaced subframe, that frame and each further held frame output zero on both slots. With `mute_en` low, held words repeat without limit.
- R6: The first frame in which no subframe was replaced releases the mute and outputs its own words.
- R7: At each frame end, `err_pin` takes the OR of the enabled flags seen in any subframe of that frame. While `locked` stays high it keeps that value until the next frame end, so one clean frame clears it.
- R8: `en_par`, `en_bip` and `en_val` each let their flag reach `err_pin` when 1 and mask it when 0.
- R9: `locked` low forces `err_pin` high in the same cycle, whatever the enable bits are.
- R10: At each frame end, `status` takes the unmasked flags of that frame: bit 3 is loss of lock, bit 2 is parity, bit 1 is biphase and bit 0 is validity.
- R11: `fmt_sel` 0 or 3 outputs all 24 bits. 1 keeps the 16 MSBs and clears bits 7:0. 2 keeps the 20 MSBs and clears bits 3:0. No rounding is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sub_valid | input | 1 | Subframe strobe, one cycle per subframe |
| sub_chan_b | input | 1 | 0 = channel A, 1 = channel B |
| sub_data | input | 24 | Decoded audio word |
| sub_par_err | input | 1 | Parity error on this subframe |
| sub_bip_err | input | 1 | Biphase coding error on this subframe |
| sub_vbit | input | 1 | Validity bit of this subframe |
| locked | input | 1 | Clock recovery lock |
| en_par | input | 1 | Parity flag reaches error pin when 1 |
| en_bip | input | 1 | Biphase flag reaches error pin when 1 |
| en_val | input | 1 | Validity flag reaches error pin when 1 |
| mute_en | input | 1 | Enables mute after extended hold |
| hold_limit | input | 8 | Consecutive held frames before mute (8 is the usual setting) |
| fmt_sel | input | 2 | Output word length select |
| left_out | output | 24 | Left sample, MSB aligned |
| right_out | output | 24 | Right sample, MSB aligned |
| out_valid | output | 1 | New stereo pair present |
| err_pin | output | 1 | Latched error indication |
| status | output | 4 | Flags of last completed frame |

## Verification
A stale last-good register shows up as a wrong repeated word on the very next frame that holds that channel. A lost update shows up as a held word where the fresh word should be, in the cycle after the B strobe. If the hold counter is wrong, the mute comes one frame early or late, or it does not release, and the bench finds this by counting held frames against the limit. A faulty error accumulator or mask leaves `err_pin` or `status` wrong for a whole frame after its end, so every scenario samples them one cycle after the B subframe.

// File: rtl/spdif_hold_pkg.sv
// Shared constants, types and the word truncation helper for the
// receiver error hold block. Assumes MSB-aligned audio words.
package spdif_hold_pkg;

    localparam int SAMPLE_W = 24;
    localparam int FLAG_W   = 4;

    // Output word length selection.
    typedef enum logic [1:0] {
        FMT_FULL  = 2'd0,
        FMT_MSB16 = 2'd1,
        FMT_MSB20 = 2'd2,
        FMT_ALT   = 2'd3
    } fmt_e;

    // Flag vector layout: {lock lost, parity, biphase, validity}.
    typedef struct packed {
        logic nolock;
        logic par;
        logic bip;
        logic val;
    } flags_t;

    // Cut a word to the selected MSB count, clearing the rest (no rounding).
    function automatic logic [SAMPLE_W-1:0] trunc_word(
        input logic [SAMPLE_W-1:0] w,
        input fmt_e                f
    );
        case (f)
            FMT_MSB16: return {w[SAMPLE_W-1 -: 16], {(SAMPLE_W-16){1'b0}}};
            FMT_MSB20: return {w[SAMPLE_W-1 -: 20], {(SAMPLE_W-20){1'b0}}};
            default:   return w;
        endcase
    endfunction

endpackage

// File: rtl/spdif_hold_chan.sv
// One channel's last-good word store. Keeps the most recent word that
// arrived clean and offers the value the store holds after this cycle.
// Assumes load is asserted only for clean words of this channel.
module spdif_hold_chan #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] word_nxt
);

    logic [W-1:0] good_q;

    // Capture a clean word; keep the old one otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_q <= '0;
        end else if (load) begin
            good_q <= din;
        end
    end

    // Value the store will hold after this cycle, for same-cycle output.
    always_comb begin
        word_nxt = load ? din : good_q;
    end

endmodule

// File: rtl/spdif_hold_timer.sv
// Counts consecutive held frames and decides the extended-hold mute.
// Assumes frame_end pulses once per frame, with frame_held valid that cycle.
module spdif_hold_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic             frame_held,
    input  logic             mute_en,
    input  logic [CNT_W-1:0] hold_limit,
    output logic             mute_now
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_nxt;

    // Next run length: saturating increment on a held frame, zero on a clean one.
    always_comb begin
        if (!frame_held) begin
            run_nxt = '0;
        end else if (run_q == CNT_MAX) begin
            run_nxt = run_q;
        end else begin
            run_nxt = run_q + 1'b1;
        end
    end

    // Update the run length once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (frame_end) begin
            run_q <= run_nxt;
        end
    end

    // Mute the current frame once the run reaches the limit.
    always_comb begin
        mute_now = mute_en && frame_held && (run_nxt >= hold_limit);
    end

endmodule

// File: rtl/spdif_err_latch.sv
// Accumulates per-subframe error flags across a frame. At frame end it
// publishes the raw flags to status and the enabled flags to the error pin.
// Assumes frame_end is only asserted together with sub_stb.
module spdif_err_latch
    import spdif_hold_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_stb,
    input  logic              frame_end,
    input  flags_t            flags_now,
    input  logic              en_par,
    input  logic              en_bip,
    input  logic              en_val,
    input  logic              locked,
    output logic              frame_bad,
    output logic              err_pin,
    output logic [FLAG_W-1:0] status
);

    flags_t acc_q;
    flags_t frame_flags;
    flags_t enabled;
    logic   err_q;

    // Flags of the frame so far, including this subframe.
    always_comb begin
        frame_flags = sub_stb ? (acc_q | flags_now) : acc_q;
        frame_bad   = |frame_flags;
        enabled     = frame_flags & flags_t'({1'b1, en_par, en_bip, en_val});
    end

    // Accumulate within a frame, publish and clear at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            err_q  <= 1'b0;
            status <= '0;
        end else if (frame_end) begin
            acc_q  <= '0;
            err_q  <= |enabled;
            status <= frame_flags;
        end else if (sub_stb) begin
            acc_q  <= frame_flags;
        end
    end

    // Loss of lock overrides the latched value at once.
    always_comb begin
        err_pin = err_q | ~locked;
    end

endmodule

// File: rtl/spdif_err_hold.sv
// Top of the receiver error hold logic. Routes A words to left and B words
// to right, replaces errored words with the last good one, mutes long
// holds when enabled and truncates outputs to the serial format.
// Assumes subframes arrive as A then B, one strobe each.
module spdif_err_hold
    import spdif_hold_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sub_valid,
    input  logic                sub_chan_b,
    input  logic [SAMPLE_W-1:0] sub_data,
    input  logic                sub_par_err,
    input  logic                sub_bip_err,
    input  logic                sub_vbit,
    input  logic                locked,
    input  logic                en_par,
    input  logic                en_bip,
    input  logic                en_val,
    input  logic                mute_en,
    input  logic [CNT_W-1:0]    hold_limit,
    input  logic [1:0]          fmt_sel,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                out_valid,
    output logic                err_pin,
    output logic [FLAG_W-1:0]   status
);

    localparam int NCH = 2;

    flags_t              flags_now;
    logic                sub_bad;
    logic                frame_end;
    logic                frame_bad;
    logic                mute_now;
    logic [SAMPLE_W-1:0] word_nxt [NCH];

    // Decode this subframe's flags and the frame boundary.
    always_comb begin
        flags_now = '{nolock: ~locked, par: sub_par_err,
                      bip: sub_bip_err, val: sub_vbit};
        sub_bad   = |flags_now;
        frame_end = sub_valid && sub_chan_b;
    end

    // One last-good store per channel: index 0 = A (left), 1 = B (right).
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic load_ch;
        assign load_ch = sub_valid && !sub_bad && (sub_chan_b == (ch == 1));
        spdif_hold_chan #(.W(SAMPLE_W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_ch),
            .din      (sub_data),
            .word_nxt (word_nxt[ch])
        );
    end

    spdif_err_latch u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_stb   (sub_valid),
        .frame_end (frame_end),
        .flags_now (flags_now),
        .en_par    (en_par),
        .en_bip    (en_bip),
        .en_val    (en_val),
        .locked    (locked),
        .frame_bad (frame_bad),
        .err_pin   (err_pin),
        .status    (status)
    );

    spdif_hold_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .frame_held (frame_bad),
        .mute_en    (mute_en),
        .hold_limit (hold_limit),
        .mute_now   (mute_now)
    );

    // Present the stereo pair at frame end, muted or truncated as required.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_out  <= '0;
            right_out <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= frame_end;
            if (frame_end) begin
                left_out  <= mute_now ? '0 : trunc_word(word_nxt[0], fmt_e'(fmt_sel));
                right_out <= mute_now ? '0 : trunc_word(word_nxt[1], fmt_e'(fmt_sel));
            end
        end
    end

endmodule

// File: rtl/spdif_err_hold_chk.sv
// Property checker for the receiver error hold top, attached by bind.
module spdif_err_hold_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sub_valid,
    input logic        sub_chan_b,
    input logic [23:0] sub_data,
    input logic        sub_par_err,
    input logic        sub_bip_err,
    input logic        sub_vbit,
    input logic        locked,
    input logic        mute_en,
    input logic [1:0]  fmt_sel,
    input logic [23:0] left_out,
    input logic [23:0] right_out,
    input logic        out_valid,
    input logic        err_pin
);

    // R2
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(sub_valid && sub_chan_b));

    // R3
    right_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && sub_chan_b && !sub_par_err && !sub_bip_err && !sub_vbit
         && locked && !mute_en && fmt_sel == 2'd0)
        |=> (right_out == $past(sub_data)));

    // R7
    err_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sub_valid && sub_chan_b) && locked) |=> (!locked || $stable(err_pin)));

    // R9
    lock_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> err_pin);

    // R11
    trunc16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(fmt_sel) == 2'd1)
        |-> (left_out[7:0] == 8'd0 && right_out[7:0] == 8'd0));

    // R11
    trunc20_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(fmt_sel) == 2'd2)
        |-> (left_out[3:0] == 4'd0 && right_out[3:0] == 4'd0));

endmodule

bind spdif_err_hold spdif_err_hold_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sub_valid   (sub_valid),
    .sub_chan_b  (sub_chan_b),
    .sub_data    (sub_data),
    .sub_par_err (sub_par_err),
    .sub_bip_err (sub_bip_err),
    .sub_vbit    (sub_vbit),
    .locked      (locked),
    .mute_en     (mute_en),
    .fmt_sel     (fmt_sel),
    .left_out    (left_out),
    .right_out   (right_out),
    .out_valid   (out_valid),
    .err_pin     (err_pin)
);

// File: tb/spdif_err_hold_test.sv
`timescale 1ns/1ps
module spdif_err_hold_test;

    localparam int CYC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sub_valid = 1'b0;
    logic        sub_chan_b = 1'b0;
    logic [23:0] sub_data = '0;
    logic        sub_par_err = 1'b0;
    logic        sub_bip_err = 1'b0;
    logic        sub_vbit = 1'b0;
    logic        locked = 1'b1;
    logic        en_par = 1'b1;
    logic        en_bip = 1'b1;
    logic        en_val = 1'b1;
    logic        mute_en = 1'b0;
    logic [7:0]  hold_limit = 8'd8;
    logic [1:0]  fmt_sel = 2'd0;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        out_valid;
    logic        err_pin;
    logic [3:0]  status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CYC/2) clk = ~clk;

    spdif_err_hold uut (
        .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_chan_b(sub_chan_b),
        .sub_data(sub_data), .sub_par_err(sub_par_err), .sub_bip_err(sub_bip_err),
        .sub_vbit(sub_vbit), .locked(locked), .en_par(en_par), .en_bip(en_bip),
        .en_val(en_val), .mute_en(mute_en), .hold_limit(hold_limit),
        .fmt_sel(fmt_sel), .left_out(left_out), .right_out(right_out),
        .out_valid(out_valid), .err_pin(err_pin), .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one subframe for one cycle; returns at the negedge after it.
    task automatic send_sub(input logic chb, input logic [23:0] d,
                            input logic p, input logic b, input logic v);
        @(negedge clk);
        sub_valid = 1'b1; sub_chan_b = chb; sub_data = d;
        sub_par_err = p; sub_bip_err = b; sub_vbit = v;
        @(negedge clk);
        sub_valid = 1'b0; sub_par_err = 1'b0; sub_bip_err = 1'b0; sub_vbit = 1'b0;
    endtask

    task automatic clean_frame(input logic [23:0] a, input logic [23:0] bw);
        send_sub(1'b0, a, 1'b0, 1'b0, 1'b0);
        send_sub(1'b1, bw, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 left", left_out, 0);
        chk("R1 right", right_out, 0);
        chk("R1 status", status, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 err_pin", err_pin, 0);
    endtask

    task automatic t_pass();
        clean_frame(24'h123456, 24'hABCDEF);
        chk("R2 out_valid pulse", out_valid, 1);
        chk("R3 left", left_out, 24'h123456);
        chk("R3 right", right_out, 24'hABCDEF);
        @(negedge clk);
        chk("R2 out_valid single", out_valid, 0);
        send_sub(1'b0, 24'h0F0F0F, 1'b0, 1'b0, 1'b0);
        chk("R2 no pulse after A", out_valid, 0);
        chk("R2 left unchanged mid frame", left_out, 24'h123456);
        send_sub(1'b1, 24'h707070, 1'b0, 1'b0, 1'b0);
        chk("R2 left from A", left_out, 24'h0F0F0F);
        chk("R2 right from B", right_out, 24'h707070);
    endtask

    task automatic t_hold();
        clean_frame(24'h111111, 24'h222222);
        send_sub(1'b0, 24'h999999, 1'b1, 1'b0, 1'b0);
        send_sub(1'b1, 24'h333333, 1'b0, 1'b0, 1'b0);
        chk("R4 parity held left", left_out, 24'h111111);
        chk("R4 right unaffected", right_out, 24'h333333);
        chk("R7 err after parity", err_pin, 1);
        chk("R10 status parity", status, 4'b0100);
        repeat (3) @(negedge clk);
        chk("R7 err held between frames", err_pin, 1);
        send_sub(1'b0, 24'h444444, 1'b0, 1'b0, 1'b0);
        send_sub(1'b1, 24'h888888, 1'b0, 1'b0, 1'b1);
        chk("R4 validity new left", left_out, 24'h444444);
        chk("R4 validity held right", right_out, 24'h333333);
        chk("R10 status validity", status, 4'b0001);
        send_sub(1'b0, 24'h777777, 1'b0, 1'b1, 1'b0);
        send_sub(1'b1, 24'h555555, 1'b0, 1'b0, 1'b0);
        chk("R4 biphase held left", left_out, 24'h444444);
        chk("R10 status biphase", status, 4'b0010);
        clean_frame(24'h010203, 24'h040506);
        chk("R7 clean frame clears", err_pin, 0);
        chk("R10 clean status", status, 0);
    endtask

    task automatic t_mute();
        mute_en = 1'b1; hold_limit = 8'd3;
        clean_frame(24'h600000, 24'h700000);
        for (int i = 1; i <= 4; i++) begin
            send_sub(1'b0, 24'hDEAD00, 1'b0, 1'b1, 1'b0);
            send_sub(1'b1, 24'hBEEF00, 1'b0, 1'b1, 1'b0);
            if (i < 3) begin
                chk("R5 held before limit", left_out, 24'h600000);
                chk("R5 held before limit right", right_out, 24'h700000);
            end else begin
                chk("R5 muted left", left_out, 0);
                chk("R5 muted right", right_out, 0);
            end
        end
        clean_frame(24'h610000, 24'h710000);
        chk("R6 release left", left_out, 24'h610000);
        chk("R6 release right", right_out, 24'h710000);
        send_sub(1'b0, 24'h0, 1'b1, 1'b0, 1'b0);
        send_sub(1'b1, 24'h0, 1'b1, 1'b0, 1'b0);
        chk("R6 run restarted", left_out, 24'h610000);
        mute_en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            send_sub(1'b0, 24'h0, 1'b0, 1'b0, 1'b1);
            send_sub(1'b1, 24'h0, 1'b0, 1'b0, 1'b1);
        end
        chk("R5 no mute when disabled", right_out, 24'h710000);
        hold_limit = 8'd8;
        clean_frame(24'h000001, 24'h000002);
    endtask

    task automatic t_mask();
        en_par = 1'b0; en_bip = 1'b0; en_val = 1'b0;
        send_sub(1'b0, 24'h1, 1'b1, 1'b0, 1'b0);
        send_sub(1'b1, 24'h2, 1'b0, 1'b1, 1'b1);
        chk("R8 all masked", err_pin, 0);
        chk("R10 status unmasked", status, 4'b0111);
        en_bip = 1'b1;
        send_sub(1'b0, 24'h1, 1'b0, 1'b1, 1'b0);
        send_sub(1'b1, 24'h2, 1'b0, 1'b0, 1'b0);
        chk("R8 biphase enabled", err_pin, 1);
        en_par = 1'b1; en_val = 1'b1;
        clean_frame(24'h3, 24'h4);
    endtask

    task automatic t_lock();
        en_par = 1'b0; en_bip = 1'b0; en_val = 1'b0;
        @(negedge clk);
        locked = 1'b0;
        #1;
        chk("R9 immediate", err_pin, 1);
        send_sub(1'b0, 24'h555555, 1'b0, 1'b0, 1'b0);
        send_sub(1'b1, 24'h666666, 1'b0, 1'b0, 1'b0);
        chk("R4 unlocked held left", left_out, 24'h000003);
        chk("R4 unlocked held right", right_out, 24'h000004);
        chk("R10 status lock", status, 4'b1000);
        chk("R9 masks ignored", err_pin, 1);
        locked = 1'b1;
        #1;
        chk("R9 latched lock error", err_pin, 1);
        clean_frame(24'h121212, 24'h343434);
        chk("R9 cleared after lock", err_pin, 0);
        en_par = 1'b1; en_bip = 1'b1; en_val = 1'b1;
    endtask

    task automatic t_trunc();
        fmt_sel = 2'd1;
        clean_frame(24'hABCDEF, 24'h13579B);
        chk("R11 16 left", left_out, 24'hABCD00);
        chk("R11 16 right", right_out, 24'h135700);
        fmt_sel = 2'd2;
        clean_frame(24'hABCDEF, 24'h13579B);
        chk("R11 20 left", left_out, 24'hABCDE0);
        chk("R11 20 right", right_out, 24'h135790);
        fmt_sel = 2'd3;
        clean_frame(24'hABCDEF, 24'h13579B);
        chk("R11 code3 full", left_out, 24'hABCDEF);
        fmt_sel = 2'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_hold();
        t_mute();
        t_mask();
        t_lock();
        t_trunc();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CYC * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule